// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single line. A frame is a low start bit, a programmable number of data bits sent least-significant first, an optional parity bit and one high stop bit. A bit-rate tick strobe from an external divider paces the output, and every bit lasts a fixed number of ticks. The line rests high between frames.

Two small configuration fields set the frame shape. A word-length code picks 7, 8, 15 or 16 data bits. A parity-enable bit adds a parity bit after the data. A parity-select code chooses even, odd, always-low or always-high parity. The 7- and 15-bit codes are meant to be used with parity, so that parity fills the eighth or sixteenth position. The 8- and 16-bit codes add parity after a full byte or halfword. Configuration writes take effect only while the init-mode input is high. The shape of each frame is captured when it starts, so a later change cannot disturb a frame that is already on the line.

A frame starts when the data-write strobe is seen while the transmitter is enabled and idle. A busy flag covers the whole frame. A one-cycle done pulse marks the end of the stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. After reset `busy` and `done` are 0.
- R2: A frame is accepted only on a cycle where `wr_stb`=1, `tx_en`=1 and `busy`=0. In the next cycle `busy` is 1 and `txd` is 0 (the start bit). A strobe with `tx_en`=0 starts nothing.
- R3: Each frame bit lasts exactly TICKS_PER_BIT (default 16) cycles in which `tick`=1. `txd` changes only in the cycle after a tick.
- R4: Data bits are sent least-significant first. The number of data bits follows `cfg_wlen`: 2'b00 = 7, 2'b01 = 8, 2'b10 = 15, 2'b11 = 16.
- R5: When parity is enabled, one parity bit follows the data bits. Its value follows `cfg_par_sel`: 2'b00 = even (XOR of the sent data bits), 2'b01 = odd (inverted XOR), 2'b10 = constant 0, 2'b11 = constant 1.
- R6: When `cfg_par_en`=0, no parity bit is sent and the stop bit follows the last data bit directly.
- R7: The last bit of a frame is a 1 (stop). In the cycle after the stop bit's final tick, `done` is 1 for exactly one cycle and `busy` is 0.
- R8: A `wr_stb` that arrives while `busy`=1 is ignored. The frame in flight continues unchanged and no extra frame follows.
- R9: `cfg_we` updates the stored configuration only when `init_mode`=1. A configuration change made during a frame does not affect that frame.
- R10: The configuration after reset is 8 data bits, even parity, parity disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Bit-rate tick strobe, one cycle wide |
| tx_en | input | 1 | Transmitter enable |
| init_mode | input | 1 | Configuration write permission |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wlen | input | 2 | Word-length code |
| cfg_par_sel | input | 2 | Parity-select code |
| cfg_par_en | input | 1 | Parity enable |
| wr_stb | input | 1 | Data-write strobe |
| wr_data | input | DATA_W | Data word to send |
| txd | output | 1 | Serial line |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse at the end of the stop bit |

## Verification
The bench uses the default DATA_W=16 and TICKS_PER_BIT=16. This makes all four word-length codes, including the full 16-bit word, reachable with every parity choice. The tick strobe is raised only on every third cycle. The bit counter therefore has to ignore the cycles between ticks, and the measured frame length in ticks shows whether it does. Frames carry random data and random configurations. Directed cases cover the reset default, disabled transmission, writes during a frame, and configuration writes made with and without init mode.

// File: rtl/uart_tx_pkg.sv
// Package: shared encodings and decode helpers for the UART frame transmitter.
// Assumes the maximum data word is 16 bits; the word-length codes never ask for more.
package uart_tx_pkg;

    // Parity-select code values (behavioural encoding, fixed by the configuration field)
    typedef enum logic [1:0] {
        PAR_EVEN = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_ZERO = 2'b10,
        PAR_ONE  = 2'b11
    } par_sel_e;

    // Word-length code values
    typedef enum logic [1:0] {
        WL_7  = 2'b00,
        WL_8  = 2'b01,
        WL_15 = 2'b10,
        WL_16 = 2'b11
    } wlen_e;

    // Frame sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } phase_e;

    // Stored frame configuration
    typedef struct packed {
        wlen_e    wlen;
        par_sel_e psel;
        logic     pen;
    } frame_cfg_t;

    localparam frame_cfg_t CFG_RESET = '{wlen: WL_8, psel: PAR_EVEN, pen: 1'b0};

    // Number of data bits carried for a word-length code
    function automatic logic [4:0] data_bits(input wlen_e w);
        case (w)
            WL_7:    return 5'd7;
            WL_8:    return 5'd8;
            WL_15:   return 5'd15;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_cfg.sv
// Module: configuration holding register.
// Accepts a new frame configuration only while init_mode is high; otherwise
// the write strobe is ignored. Resets to 8 data bits, even parity, parity off.
module uart_tx_cfg
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_mode,
    input  logic       cfg_we,
    input  logic [1:0] wlen_in,
    input  logic [1:0] psel_in,
    input  logic       pen_in,
    output frame_cfg_t cfg_q
);

    // Purpose: capture configuration writes gated by init mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we && init_mode) begin
            cfg_q.wlen <= wlen_e'(wlen_in);
            cfg_q.psel <= par_sel_e'(psel_in);
            cfg_q.pen  <= pen_in;
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
// Module: parity unit.
// Computes the parity bit over the lowest n_bits of data for the selected mode.
// Purely combinational; assumes n_bits <= DATA_W.
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  n_bits,
    input  par_sel_e          sel,
    output logic              par_bit
);

    logic [DATA_W-1:0] mask;
    logic              xor_all;

    // Build a mask of the bit positions that go on the line
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (g < int'(n_bits));
    end

    assign xor_all = ^(data & mask);

    // Purpose: select the parity value for the configured mode
    always_comb begin
        case (sel)
            PAR_EVEN: par_bit = xor_all;
            PAR_ODD:  par_bit = ~xor_all;
            PAR_ZERO: par_bit = 1'b0;
            default:  par_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: frame sequencer and shift register.
// On load it captures the data word, bit count and parity decision, then walks
// start, data (LSB first), optional parity and stop, each TICKS_PER_BIT ticks long.
// Assumes load is only raised while idle.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int CNT_W         = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_bits,
    input  logic              load_pen,
    input  logic              load_par,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [TCW-1:0] TLAST = TCW'(TICKS_PER_BIT - 1);

    phase_e             phase;
    logic [DATA_W-1:0]  shreg;
    logic [CNT_W-1:0]   left;
    logic [TCW-1:0]     tcnt;
    logic               has_par;
    logic               par_q;
    logic               bit_end;

    assign bit_end = tick && (tcnt == TLAST);
    assign busy    = (phase != PH_IDLE);

    // Purpose: drive the line level from the current phase
    always_comb begin
        case (phase)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = shreg[0];
            PH_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

    // Purpose: count ticks within the current bit
    always_ff @(posedge clk) begin
        if (!rst_n || load || phase == PH_IDLE) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
        end
    end

    // Purpose: advance the frame phases and shift out data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            left    <= '0;
            has_par <= 1'b0;
            par_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (load) begin
                    phase   <= PH_START;
                    shreg   <= load_data;
                    left    <= load_bits;
                    has_par <= load_pen;
                    par_q   <= load_par;
                end
            end else if (bit_end) begin
                case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        left  <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            phase <= has_par ? PH_PARITY : PH_STOP;
                        end
                    end
                    PH_PARITY: phase <= PH_STOP;
                    default: begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Module: top of the UART frame transmitter.
// Holds the configuration, decodes the frame shape, computes parity and
// starts the sequencer when an enabled write arrives while idle.
// Assumes DATA_W >= 16 so every word-length code fits.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              init_mode,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wlen,
    input  logic [1:0]        cfg_par_sel,
    input  logic              cfg_par_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    frame_cfg_t       cfg;
    logic [CNT_W-1:0] n_bits;
    logic             par_bit;
    logic             accept;

    assign n_bits = CNT_W'(data_bits(cfg.wlen));
    assign accept = wr_stb && tx_en && !busy;

    uart_tx_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .cfg_we    (cfg_we),
        .wlen_in   (cfg_wlen),
        .psel_in   (cfg_par_sel),
        .pen_in    (cfg_par_en),
        .cfg_q     (cfg)
    );

    uart_tx_parity #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_par (
        .data    (wr_data),
        .n_bits  (n_bits),
        .sel     (cfg.psel),
        .par_bit (par_bit)
    );

    uart_tx_shifter #(
        .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (accept),
        .load_data (wr_data),
        .load_bits (n_bits),
        .load_pen  (cfg.pen),
        .load_par  (par_bit),
        .txd       (txd),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/uart_tx_chk.sv
// Module: assertion checker for uart_frame_tx, attached by bind below.
module uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_en,
    input logic wr_stb,
    input logic txd,
    input logic busy,
    input logic done
);

    // R1: the line rests high outside a frame
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: an enabled write while idle starts a frame with a low start bit
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && !busy) |=> (busy && !txd));

    // R2: a strobe without enable leaves the block idle
    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !busy) |=> !busy);

    // R3: within a frame the line moves only after a tick
    p_tick_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(txd));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows the high stop bit and ends busy
    p_done_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $past(txd)));

endmodule

bind uart_frame_tx uart_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .tx_en  (tx_en),
    .wr_stb (wr_stb),
    .txd    (txd),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_uart_frame_tx.sv
// Bench: drives frames through uart_frame_tx and checks the serial line bit by bit
// against a model built from the requirements.
module sim_uart_frame_tx;

    localparam int DATA_W   = 16;
    localparam int TPB      = 16;
    localparam int TICK_DIV = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              tx_en = 1'b0;
    logic              init_mode = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_wlen = 2'b00;
    logic [1:0]        cfg_par_sel = 2'b00;
    logic              cfg_par_en = 1'b0;
    logic              wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              txd, busy, done;

    int n_checks = 0;
    int n_fails  = 0;

    // Model configuration (R10 reset default)
    logic [1:0] m_wlen = 2'b01;
    logic [1:0] m_sel  = 2'b00;
    logic       m_pen  = 1'b0;

    uart_frame_tx #(.DATA_W(DATA_W), .TICKS_PER_BIT(TPB)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
        .init_mode(init_mode), .cfg_we(cfg_we), .cfg_wlen(cfg_wlen),
        .cfg_par_sel(cfg_par_sel), .cfg_par_en(cfg_par_en),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    // Tick strobe every TICK_DIV cycles, changed after the edge
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            tick <= (div == 0);
            div = (div + 1) % TICK_DIV;
        end
    end

    function automatic int exp_count(input logic [1:0] w);
        case (w)
            2'b00: return 7;
            2'b01: return 8;
            2'b10: return 15;
            default: return 16;
        endcase
    endfunction

    function automatic logic exp_par(input logic [15:0] d, input int n, input logic [1:0] s);
        logic x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        case (s)
            2'b00: return x;
            2'b01: return ~x;
            2'b10: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] w, input logic [1:0] s, input logic p, input logic im);
        @(negedge clk);
        cfg_wlen = w; cfg_par_sel = s; cfg_par_en = p; init_mode = im; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; init_mode = 1'b0;
        if (im) begin m_wlen = w; m_sel = s; m_pen = p; end
    endtask

    // Send one frame and check every bit at its middle tick.
    // inj: during the frame, pulse a data write (R8) and an init-mode config write (R9).
    task automatic run_frame(input logic [15:0] d, input bit inj);
        int n = exp_count(m_wlen);
        bit pen = m_pen;
        logic par = exp_par(d, n, m_sel);
        int len = n + (pen ? 1 : 0) + 2;
        int cnt = 0;
        int guard = 0;
        int bad_data = 0, bad_par = 0, bad_frame = 0;
        bit injected = 0, clear = 0;
        @(negedge clk);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(busy === 1'b1 && txd === 1'b0, "R2 start", {busy, txd}, 2);
        while (done !== 1'b1 && guard < 20000) begin
            if (clear) begin wr_stb = 1'b0; cfg_we = 1'b0; init_mode = 1'b0; clear = 0; end
            if (tick && busy) begin
                if (cnt % TPB == TPB / 2) begin
                    int b = cnt / TPB;
                    logic e;
                    if (b == 0) e = 1'b0;
                    else if (b <= n) e = d[b-1];
                    else if (pen && b == n + 1) e = par;
                    else e = 1'b1;
                    if (txd !== e) begin
                        if (b >= 1 && b <= n) bad_data++;
                        else if (pen && b == n + 1) bad_par++;
                        else bad_frame++;
                    end
                end
                cnt++;
            end
            if (inj && !injected && cnt == 40) begin
                wr_data = ~d; wr_stb = 1'b1;
                cfg_wlen = ~m_wlen; cfg_par_sel = ~m_sel; cfg_par_en = ~m_pen;
                init_mode = 1'b1; cfg_we = 1'b1;
                injected = 1; clear = 1;
            end
            @(negedge clk);
            guard++;
        end
        wr_stb = 1'b0; cfg_we = 1'b0; init_mode = 1'b0;
        if (injected) begin m_wlen = ~m_wlen; m_sel = ~m_sel; m_pen = ~m_pen; end
        check(bad_data == 0, "R4 data bits LSB first", bad_data, 0);
        check(bad_par == 0, "R5 parity bit", bad_par, 0);
        check(bad_frame == 0, "R7 start/stop levels", bad_frame, 0);
        check(cnt == len * TPB, pen ? "R3 frame length" : "R6 no parity bit", cnt, len * TPB);
        check(done === 1'b1 && busy === 1'b0, "R7 done at end", {done, busy}, 2);
        @(negedge clk);
        check(done === 1'b0 && txd === 1'b1, "R7 done one cycle", {done, txd}, 1);
        if (inj) begin
            repeat (2 * TPB * TICK_DIV) @(negedge clk);
            check(busy === 1'b0, "R8 write during frame ignored", busy, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset idle",
              {txd, busy, done}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", {txd, busy}, 2);

        // R2: strobe with transmitter disabled starts nothing
        wr_data = 16'h00ff; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (50) begin
            @(negedge clk);
            if (busy !== 1'b0 || txd !== 1'b1) break;
        end
        check(busy === 1'b0 && txd === 1'b1, "R2 disabled no frame", {busy, txd}, 1);

        tx_en = 1'b1;
        // R10 default configuration: 8 data bits, no parity
        run_frame(16'h00a5, 0);

        // R9: config write without init mode is ignored
        write_cfg(2'b11, 2'b01, 1'b1, 1'b0);
        run_frame(16'h5a3c, 0);

        // R5: each parity mode with directed data
        for (int s = 0; s < 4; s++) begin
            write_cfg(2'b00, 2'(s), 1'b1, 1'b1);
            run_frame(16'h0035, 0);
            write_cfg(2'b11, 2'(s), 1'b1, 1'b1);
            run_frame(16'hffff, 0);
        end

        // R6: 7- and 15-bit codes with parity off
        write_cfg(2'b00, 2'b01, 1'b0, 1'b1);
        run_frame(16'h007f, 0);
        write_cfg(2'b10, 2'b00, 1'b0, 1'b1);
        run_frame(16'h7001, 0);

        // R8, R9: writes during a frame
        write_cfg(2'b01, 2'b00, 1'b1, 1'b1);
        run_frame(16'h0081, 1);
        run_frame(16'h1234, 1);

        // Random frames
        for (int k = 0; k < 30; k++) begin
            write_cfg(2'($urandom), 2'($urandom), 1'($urandom), 1'b1);
            run_frame(16'($urandom), ($urandom % 4) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule